// File: doc/BRIEF.md
# Processor Reset Monitor with Deep-Sleep Gate

This block watches the reset line of an application processor and turns it into two signals for the security controller that hosts it. Every time the line is seen going low, the block sends a one-cycle reset request to the local TPM logic. A TPM reset is needed on every processor reboot; if it is missed, the first startup command fails. The second output is a level that permits the controller to enter deep sleep. It is raised only when the line has been held low for longer than a threshold (one second at 24 MHz by default), which is taken to mean that the processor has entered a low-power state.

A decoded strap input chooses how the line is read. In pulse style the processor only pulses its reset line, so a long low carries no meaning and deep sleep is never permitted. In level style the line stays low while the processor is in reset or in low power, and the threshold rule applies. The chosen style is reported as a one-hot pair of status bits. The block can also reset the processor on command. It does this by pulling an open-drain reset output low for a fixed number of cycles. That forced low comes back on the monitored line like any other reset.

Top module: `soc_rst_monitor`

## Requirements
- R1: `style_o` is one-hot and matches `mode_i`: `style_o[0]` is high in pulse style (`mode_i`=0) and `style_o[1]` is high in level style (`mode_i`=1).
- R2: Each low episode of `soc_rst_ni` that lasts at least one clock produces exactly one `tpm_rst_o` pulse, and that pulse is one cycle wide. This holds in both styles.
- R3: In level style, `sleep_ok_o` rises if `soc_rst_ni` stays low for more than `LOW_CYCLES` consecutive clocks. It does not rise if the low lasts `LOW_CYCLES` clocks or fewer.
- R4: In pulse style, `sleep_ok_o` stays low whatever the length of the low episode.
- R5: `sleep_ok_o` falls within three clocks after `soc_rst_ni` returns high.
- R6: A `force_rst_i` request made while idle drives `soc_rst_pull_o` high for exactly `PULSE_CYCLES` clocks. The processor reset line is pulled low while `soc_rst_pull_o` is high and is released otherwise.
- R7: A `force_rst_i` request made while a forced pulse is in progress has no effect. The pulse keeps its original length and no second pulse follows.
- R8: After reset, `tpm_rst_o`, `sleep_ok_o` and `soc_rst_pull_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Decoded strap: 0 pulse style, 1 level style |
| soc_rst_ni | input | 1 | Processor reset indication, asynchronous, active low |
| force_rst_i | input | 1 | Request to reset the processor |
| style_o | output | 2 | One-hot style status |
| tpm_rst_o | output | 1 | One-cycle TPM reset request |
| sleep_ok_o | output | 1 | Deep sleep permitted |
| soc_rst_pull_o | output | 1 | Open-drain enable; 1 pulls the processor reset low |

## Verification
Low episodes are driven with random lengths clustered around `LOW_CYCLES`. Directed episodes of one clock, of exactly `LOW_CYCLES` and of `LOW_CYCLES`+1 are added. The random lengths separate the greater-than threshold from a greater-or-equal one, and the one-clock episode shows that the edge detector misses no short pulse. The same episodes are repeated in both styles, which shows that the TPM request is issued regardless of style while sleep permission depends on it. Forced resets are looped back onto the monitored line. Repeated requests are sent during a forced pulse to check its length and that the requests are ignored.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic {
    STYLE_PULSE = 1'b0,
    STYLE_LEVEL = 1'b1
  } rst_style_e;
endpackage

// File: rtl/rsm_sync.sv
module rsm_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rsm_low_timer.sv
module rsm_low_timer #(
  parameter int unsigned LOW_CYCLES = 24_000_000,
  localparam int unsigned CW = $clog2(LOW_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic sleep_en_i,
  output logic fall_o,
  output logic sleep_o
);
  localparam logic [CW-1:0] LIMIT = CW'(LOW_CYCLES);

  logic          line_q;
  logic          fall_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      fall_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      line_q <= line_i;
      fall_q <= line_q & ~line_i;
      if (line_i)             cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fall_o  = fall_q;
  // saturated count means low for more than LOW_CYCLES
  assign sleep_o = sleep_en_i & ~line_i & (cnt_q == LIMIT);
endmodule

// File: rtl/rsm_pulser.sv
module rsm_pulser #(
  parameter int unsigned PULSE_CYCLES = 1000,
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pull_o
);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end else if (req_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign pull_o = busy_q;
endmodule

// File: rtl/soc_rst_monitor.sv
module soc_rst_monitor #(
  parameter int unsigned LOW_CYCLES   = 24_000_000,
  parameter int unsigned PULSE_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i,
  input  logic       soc_rst_ni,
  input  logic       force_rst_i,
  output logic [1:0] style_o,
  output logic       tpm_rst_o,
  output logic       sleep_ok_o,
  output logic       soc_rst_pull_o
);
  import rsm_pkg::*;

  rst_style_e style;
  logic       line_s;

  assign style   = rst_style_e'(mode_i);
  assign style_o = {style == STYLE_LEVEL, style == STYLE_PULSE};

  rsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (soc_rst_ni),
    .q_o   (line_s)
  );

  rsm_low_timer #(.LOW_CYCLES(LOW_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_s),
    .sleep_en_i(style == STYLE_LEVEL),
    .fall_o    (tpm_rst_o),
    .sleep_o   (sleep_ok_o)
  );

  rsm_pulser #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (force_rst_i),
    .pull_o(soc_rst_pull_o)
  );
endmodule

// File: rtl/soc_rst_monitor_chk.sv
module soc_rst_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_i,
  input logic       soc_rst_ni,
  input logic       force_rst_i,
  input logic [1:0] style_o,
  input logic       tpm_rst_o,
  input logic       sleep_ok_o,
  input logic       soc_rst_pull_o
);
  assert_style_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(style_o) && (style_o[1] == mode_i));

  assert_tpm_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpm_rst_o |=> !tpm_rst_o);

  assert_tpm_after_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpm_rst_o |-> (!$past(soc_rst_ni, 3) && $past(soc_rst_ni, 4)));

  assert_no_sleep_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ok_o |-> mode_i);

  assert_sleep_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soc_rst_ni && $past(soc_rst_ni)) |=> !sleep_ok_o);

  assert_pull_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soc_rst_pull_o) |-> $past(force_rst_i));
endmodule

bind soc_rst_monitor soc_rst_monitor_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_i        (mode_i),
  .soc_rst_ni    (soc_rst_ni),
  .force_rst_i   (force_rst_i),
  .style_o       (style_o),
  .tpm_rst_o     (tpm_rst_o),
  .sleep_ok_o    (sleep_ok_o),
  .soc_rst_pull_o(soc_rst_pull_o)
);

// File: tb/test_soc_rst_monitor.sv
`timescale 1ns/1ps
module test_soc_rst_monitor;
  localparam int LOW   = 200;
  localparam int PULSE = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       ext_low = 1'b0;
  logic       force_rst = 1'b0;
  logic [1:0] style;
  logic       tpm_rst, sleep_ok, pull;
  logic       soc_line;

  int tests = 0, fails = 0;
  int tpm_cnt = 0, pull_cnt = 0;
  bit sleep_seen = 0;
  bit done = 0;

  assign soc_line = ~(ext_low | pull);

  always #2.5 clk = ~clk;

  soc_rst_monitor #(.LOW_CYCLES(LOW), .PULSE_CYCLES(PULSE)) i_soc_rst_monitor (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .soc_rst_ni(soc_line),
    .force_rst_i(force_rst), .style_o(style), .tpm_rst_o(tpm_rst),
    .sleep_ok_o(sleep_ok), .soc_rst_pull_o(pull)
  );

  always @(negedge clk) begin
    tpm_cnt  += int'(tpm_rst);
    pull_cnt += int'(pull);
    if (sleep_ok) sleep_seen = 1;
  end

  function automatic bit exp_sleep(bit m, int d);
    return m && (d > LOW);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(bit m);
    rst_n = 1'b0; mode = m; ext_low = 1'b0; force_rst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic episode(int d);
    int t0 = tpm_cnt;
    sleep_seen = 0;
    ext_low = 1'b1;
    repeat (d) @(negedge clk);
    ext_low = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 sleep cleared after release", int'(sleep_ok), 0);
    repeat (2) @(negedge clk);
    chk("R2 one tpm pulse per episode", tpm_cnt - t0, 1);
    chk(mode ? "R3 level-style sleep" : "R4 pulse-style sleep", int'(sleep_seen),
        int'(exp_sleep(mode, d)));
  endtask

  task automatic forced(int extra_reqs);
    int p0 = pull_cnt;
    int t0 = tpm_cnt;
    force_rst = 1'b1;
    @(negedge clk);
    force_rst = 1'b0;
    for (int i = 0; i < extra_reqs; i++) begin
      repeat (2) @(negedge clk);
      force_rst = 1'b1;
      @(negedge clk);
      force_rst = 1'b0;
    end
    repeat (PULSE + 10) @(negedge clk);
    chk(extra_reqs > 0 ? "R7 pull length with extra requests" : "R6 pull length",
        pull_cnt - p0, PULSE);
    chk("R2 forced reset seen by tpm", tpm_cnt - t0, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    chk("R8 tpm_rst in reset", int'(tpm_rst), 0);
    chk("R8 sleep_ok in reset", int'(sleep_ok), 0);
    chk("R8 pull in reset", int'(pull), 0);

    for (int m = 0; m < 2; m++) begin
      do_reset(bit'(m));
      chk("R8 tpm_rst after reset", int'(tpm_rst), 0);
      chk("R8 pull after reset", int'(pull), 0);
      chk("R1 style bits", int'(style), m ? 2 : 1);
      episode(1);
      episode(LOW);
      episode(LOW + 1);
      episode(LOW + 40);
      for (int k = 0; k < 12; k++) begin
        episode(int'($urandom_range(LOW + 8, LOW - 8)));
        repeat (int'($urandom_range(6, 1))) @(negedge clk);
      end
      for (int k = 0; k < 4; k++) episode(int'($urandom_range(30, 1)));
      forced(0);
      forced(3);
      chk(m ? "R3 no sleep from forced pulse" : "R4 no sleep from forced pulse",
          int'(sleep_ok), 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule